// File: doc/BRIEF.md
# Remappable Memory-Select Address Decoder

This block sits on the single system bus of a small processor and turns each 32-bit bus address into one select line for the region it addresses. It also gives a zero-based byte offset into that region. The regions are a boot ROM, four program-flash banks, a data flash, a data RAM, thirteen control-peripheral windows and a group of system-peripheral windows. The select and offset outputs are combinational in the address, so the memories and peripherals see them in the same cycle as the address.

What sits at address zero depends on a 2-bit mapping mode held in a register. After reset the boot ROM is mirrored through the whole low window and the flash banks sit higher up. In the first flash mode the four banks move down to address zero in order and the ROM moves up to 0x20000. The second flash mode is the same, except that the two bank pairs trade places, so banks 2 and 3 answer from zero. Boot code changes the mode through a one-cycle write-enable port.

Top module: `memsel_decoder`

## Requirements
- R1: A synchronous active-high reset puts the mapping mode at 2'b00 (boot mode). In boot mode address 0 selects the boot ROM.
- R2: In boot mode, every address below 0x40000 selects the ROM, with offset equal to the address bits [12:0]. The 8 KB image therefore repeats every 8 KB.
- R3: In boot mode, flash bank b (0..3) answers from 0x40000 + b*0x8000 for 32 KB, with offset equal to the address minus that base.
- R4: In mode 2'b01, bank b answers from b*0x8000 for 32 KB, with offset equal to the address bits [14:0]. The ROM answers from 0x20000 to 0x21FFF, with offset equal to the address minus 0x20000, and does not repeat.
- R5: In mode 2'b10, the slot at b*0x8000 holds bank (b+2) mod 4, so the order from zero is 2, 3, 0, 1. Offsets and the ROM are as in R4.
- R6: In every mode, the 2 KB data flash at 0x69800 and the 8 KB data RAM at 0x6A000 are selected, with offset equal to the address minus the base.
- R7: In every mode, control window k (0..12) covers 0x120000 + k*0x10000 for 256 bytes and drives ctl_sel[k], with offset equal to the address bits [7:0].
- R8: In every mode, the 256-byte system windows drive these lines: sys_sel[0] at 0xFFF7FD00, sys_sel[1] at 0xFFF7FA00, sys_sel[2] at 0xFFF7F600, sys_sel[3] at 0xFFF7F000. sys_sel[4] serves both 0xFFF7EC00 and 0xFFF7ED00. The offset is the address bits [7:0].
- R9: An address outside every region asserts no select, raises decode_err and gives offset 0.
- R10: A write with mode_we high and data 00, 01 or 10 sets the mode at the clock edge. Decoding uses the new mode from the cycle after the write. A write of 11 leaves the mode unchanged.
- R11: At most one select line is high at any time, and decode_err is high exactly when none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mapping-mode write strobe |
| mode_wdata | input | 2 | Mapping-mode write value |
| mode_o | output | 2 | Current mapping mode |
| addr | input | 32 | Bus byte address |
| rom_sel | output | 1 | Boot ROM select |
| flash_sel | output | 4 | Program-flash bank selects, bit b for physical bank b |
| dflash_sel | output | 1 | Data flash select |
| ram_sel | output | 1 | Data RAM select |
| ctl_sel | output | 13 | Control-peripheral window selects |
| sys_sel | output | 5 | System-peripheral selects |
| decode_err | output | 1 | No region hit |
| local_offset | output | 32 | Byte offset within the selected region |

## Verification
The only state in this block is the mapping mode. If it holds a wrong value, the error shows at the first access below 0x60000: that access selects the wrong one of ROM, flash and bank, or sees a ROM mirror where it should see a decode error. mode_o shows the stored value directly, one edge after the write. A fault in the combinational decode appears in the same cycle as the address. For that reason the bench sweeps the first byte, last byte and neighbour bytes of every region in all three modes. It checks each result against an arithmetic reference map and also checks that exactly one of the select lines and decode_err is high.

// File: rtl/memsel_pkg.sv
package memsel_pkg;
  typedef enum logic [1:0] {
    MAP_BOOT    = 2'b00,
    MAP_FLASH_A = 2'b01,
    MAP_FLASH_B = 2'b10
  } map_mode_e;
endpackage

// File: rtl/memsel_mode_reg.sv
module memsel_mode_reg
  import memsel_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      we,
  input  logic [1:0] wdata,
  output map_mode_e mode_q
);
  // The reserved code 2'b11 is dropped, so the register only ever holds a legal mode.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MAP_BOOT;
    end else if (we && (wdata != 2'b11)) begin
      mode_q <= map_mode_e'(wdata);
    end
  end
endmodule

// File: rtl/memsel_prog_dec.sv
module memsel_prog_dec
  import memsel_pkg::*;
#(
  parameter int          ROM_AW          = 13,
  parameter int          BANK_AW         = 15,
  parameter int          NBANK           = 4,
  parameter logic [31:0] BOOT_FLASH_BASE = 32'h0004_0000,
  parameter logic [31:0] FLASH_ROM_BASE  = 32'h0002_0000
) (
  input  logic [31:0]      addr,
  input  map_mode_e        mode,
  output logic             rom_hit,
  output logic [NBANK-1:0] bank_hit,
  output logic [31:0]      offset
);
  localparam int          BSEL_W    = $clog2(NBANK);
  localparam logic [31:0] ROM_SPAN  = 32'd1 << ROM_AW;
  localparam logic [31:0] FLASH_SPAN = 32'(NBANK) << BANK_AW;
  localparam logic [BSEL_W-1:0] SWAP_MASK = BSEL_W'(1) << (BSEL_W - 1);

  logic [31:0]       rel_boot;
  logic [31:0]       rel_rom;
  logic [BSEL_W-1:0] slot;

  assign rel_boot = addr - BOOT_FLASH_BASE;
  assign rel_rom  = addr - FLASH_ROM_BASE;

  always_comb begin
    rom_hit  = 1'b0;
    bank_hit = '0;
    offset   = '0;
    slot     = '0;
    case (mode)
      MAP_BOOT: begin
        if (addr < BOOT_FLASH_BASE) begin
          // The ROM image is mirrored: only the low address bits index it.
          rom_hit = 1'b1;
          offset  = {{(32-ROM_AW){1'b0}}, addr[ROM_AW-1:0]};
        end else if (rel_boot < FLASH_SPAN) begin
          slot           = rel_boot[BANK_AW +: BSEL_W];
          bank_hit[slot] = 1'b1;
          offset         = {{(32-BANK_AW){1'b0}}, rel_boot[BANK_AW-1:0]};
        end
      end
      MAP_FLASH_A, MAP_FLASH_B: begin
        if (addr < FLASH_SPAN) begin
          slot = addr[BANK_AW +: BSEL_W];
          if (mode == MAP_FLASH_B) begin
            // Inverting the top bank bit swaps the lower and upper bank pairs.
            slot = slot ^ SWAP_MASK;
          end
          bank_hit[slot] = 1'b1;
          offset         = {{(32-BANK_AW){1'b0}}, addr[BANK_AW-1:0]};
        end else if (rel_rom < ROM_SPAN) begin
          rom_hit = 1'b1;
          offset  = rel_rom;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/memsel_fixed_dec.sv
module memsel_fixed_dec #(
  parameter logic [31:0] DF_BASE    = 32'h0006_9800,
  parameter int          DF_AW      = 11,
  parameter logic [31:0] RAM_BASE   = 32'h0006_A000,
  parameter int          RAM_AW     = 13,
  parameter logic [31:0] CTL_BASE   = 32'h0012_0000,
  parameter logic [31:0] CTL_STRIDE = 32'h0001_0000,
  parameter int          CTL_N      = 13,
  parameter int          WIN_AW     = 8,
  parameter int          SYS_WIN    = 6,
  parameter int          SYS_N      = 5,
  parameter logic [SYS_WIN*32-1:0] SYS_BASES = {
    32'hFFF7_ED00, 32'hFFF7_EC00, 32'hFFF7_F000,
    32'hFFF7_F600, 32'hFFF7_FA00, 32'hFFF7_FD00},
  parameter int          LINE_W     = 3,
  parameter logic [SYS_WIN*LINE_W-1:0] SYS_LINE = {
    3'd4, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}
) (
  input  logic [31:0]      addr,
  output logic             df_hit,
  output logic             ram_hit,
  output logic [CTL_N-1:0] ctl_hit,
  output logic [SYS_N-1:0] sys_hit,
  output logic [31:0]      offset
);
  localparam logic [31:0] DF_SPAN  = 32'd1 << DF_AW;
  localparam logic [31:0] RAM_SPAN = 32'd1 << RAM_AW;

  logic [31:0]        df_rel;
  logic [31:0]        ram_rel;
  logic [SYS_WIN-1:0] win_hit;

  assign df_rel  = addr - DF_BASE;
  assign ram_rel = addr - RAM_BASE;
  assign df_hit  = df_rel < DF_SPAN;
  assign ram_hit = ram_rel < RAM_SPAN;

  for (genvar k = 0; k < CTL_N; k++) begin : g_ctl
    localparam logic [31:0] KBASE = CTL_BASE + CTL_STRIDE * 32'(k);
    assign ctl_hit[k] = (addr[31:WIN_AW] == KBASE[31:WIN_AW]);
  end

  for (genvar w = 0; w < SYS_WIN; w++) begin : g_sys
    assign win_hit[w] = (addr[31:WIN_AW] == SYS_BASES[w*32+WIN_AW +: 32-WIN_AW]);
  end

  // Several windows may feed one line; the line is the OR of its windows.
  always_comb begin
    sys_hit = '0;
    for (int w = 0; w < SYS_WIN; w++) begin
      if (win_hit[w]) sys_hit[SYS_LINE[w*LINE_W +: LINE_W]] = 1'b1;
    end
  end

  always_comb begin
    if (df_hit)                         offset = df_rel;
    else if (ram_hit)                   offset = ram_rel;
    else if ((|ctl_hit) || (|sys_hit))  offset = {{(32-WIN_AW){1'b0}}, addr[WIN_AW-1:0]};
    else                                offset = '0;
  end
endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder
  import memsel_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int CTL_N  = 13,
  parameter int SYS_N  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_we,
  input  logic [1:0]       mode_wdata,
  output logic [1:0]       mode_o,
  input  logic [31:0]      addr,
  output logic             rom_sel,
  output logic [NBANK-1:0] flash_sel,
  output logic             dflash_sel,
  output logic             ram_sel,
  output logic [CTL_N-1:0] ctl_sel,
  output logic [SYS_N-1:0] sys_sel,
  output logic             decode_err,
  output logic [31:0]      local_offset
);
  map_mode_e   mode_q;
  logic [31:0] prog_off;
  logic [31:0] fix_off;

  memsel_mode_reg u_mode (
    .clk   (clk),
    .rst   (rst),
    .we    (mode_we),
    .wdata (mode_wdata),
    .mode_q(mode_q)
  );

  memsel_prog_dec #(.NBANK(NBANK)) u_prog (
    .addr    (addr),
    .mode    (mode_q),
    .rom_hit (rom_sel),
    .bank_hit(flash_sel),
    .offset  (prog_off)
  );

  memsel_fixed_dec #(.CTL_N(CTL_N), .SYS_N(SYS_N)) u_fixed (
    .addr   (addr),
    .df_hit (dflash_sel),
    .ram_hit(ram_sel),
    .ctl_hit(ctl_sel),
    .sys_hit(sys_sel),
    .offset (fix_off)
  );

  // The two decoders cover disjoint address ranges and each returns zero on a miss.
  assign mode_o       = mode_q;
  assign local_offset = prog_off | fix_off;
  assign decode_err   = ~(rom_sel | (|flash_sel) | dflash_sel | ram_sel |
                          (|ctl_sel) | (|sys_sel));
endmodule

// File: rtl/memsel_decoder_chk.sv
module memsel_decoder_chk #(
  parameter int NBANK = 4,
  parameter int CTL_N = 13,
  parameter int SYS_N = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_we,
  input logic [1:0]       mode_wdata,
  input logic [1:0]       mode_o,
  input logic [31:0]      addr,
  input logic             rom_sel,
  input logic [NBANK-1:0] flash_sel,
  input logic             dflash_sel,
  input logic             ram_sel,
  input logic [CTL_N-1:0] ctl_sel,
  input logic [SYS_N-1:0] sys_sel,
  input logic             decode_err,
  input logic [31:0]      local_offset
);
  logic [NBANK+CTL_N+SYS_N+2:0] all_sel;
  assign all_sel = {rom_sel, flash_sel, dflash_sel, ram_sel, ctl_sel, sys_sel};

  a_r1_reset_boot: assert property (@(posedge clk) rst |=> mode_o == 2'b00);

  a_r10_reserved_ignored: assert property (@(posedge clk) disable iff (rst)
    (mode_we && mode_wdata == 2'b11) |=> $stable(mode_o));

  a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
    (mode_we && mode_wdata != 2'b11) |=> mode_o == $past(mode_wdata));

  a_r11_single_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(all_sel) && (decode_err == (all_sel == '0)));

  a_r2_rom_mirror: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b00 && addr < 32'h0004_0000) |->
      (rom_sel && local_offset == {19'b0, addr[12:0]}));

  a_r6_data_fixed: assert property (@(posedge clk) disable iff (rst)
    (addr >= 32'h0006_9800 && addr < 32'h0006_A000) |->
      (dflash_sel && local_offset == addr - 32'h0006_9800));

  a_r9_err_zero_offset: assert property (@(posedge clk) disable iff (rst)
    decode_err |-> local_offset == 32'd0);
endmodule

bind memsel_decoder memsel_decoder_chk #(.NBANK(NBANK), .CTL_N(CTL_N), .SYS_N(SYS_N)) u_chk (.*);

// File: tb/memsel_decoder_bench.sv
module memsel_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_we = 1'b0;
  logic [1:0]  mode_wdata = 2'b00;
  logic [1:0]  mode_o;
  logic [31:0] addr = 32'd0;
  logic        rom_sel;
  logic [3:0]  flash_sel;
  logic        dflash_sel;
  logic        ram_sel;
  logic [12:0] ctl_sel;
  logic [4:0]  sys_sel;
  logic        decode_err;
  logic [31:0] local_offset;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  memsel_decoder u_memsel_decoder (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .mode_o(mode_o), .addr(addr), .rom_sel(rom_sel), .flash_sel(flash_sel),
    .dflash_sel(dflash_sel), .ram_sel(ram_sel), .ctl_sel(ctl_sel),
    .sys_sel(sys_sel), .decode_err(decode_err), .local_offset(local_offset)
  );

  // Observed vector: [25] rom, [24:21] flash, [20] dflash, [19] ram, [18:6] ctl, [5:1] sys, [0] err
  function automatic logic [25:0] observed();
    return {rom_sel, flash_sel, dflash_sel, ram_sel, ctl_sel, sys_sel, decode_err};
  endfunction

  function automatic logic [31:0] sys_base(int i);
    case (i)
      0: return 32'hFFF7_FD00;
      1: return 32'hFFF7_FA00;
      2: return 32'hFFF7_F600;
      3: return 32'hFFF7_F000;
      4: return 32'hFFF7_EC00;
      default: return 32'hFFF7_ED00;
    endcase
  endfunction

  function automatic int sys_line(int i);
    return (i >= 4) ? 4 : i;
  endfunction

  // Reference map built from the requirement text: returns {vector, offset}, and a tag.
  function automatic logic [57:0] expect_map(input logic [1:0] m, input logic [31:0] a,
                                             output string tag);
    logic [25:0] v = '0;
    logic [31:0] off = '0;
    longint ua = a;
    tag = "R9";
    if (m == 2'b00 && ua < 'h40000) begin
      v[25] = 1'b1; off = 32'(ua % 8192); tag = "R2";
    end else if (m == 2'b00 && ua >= 'h40000 && ua < 'h60000) begin
      v[21 + int'((ua - 'h40000) / 'h8000)] = 1'b1;
      off = 32'((ua - 'h40000) % 'h8000); tag = "R3";
    end else if (m != 2'b00 && ua < 'h20000) begin
      int slot = int'(ua / 'h8000);
      v[21 + ((m == 2'b01) ? slot : (slot + 2) % 4)] = 1'b1;
      off = 32'(ua % 'h8000); tag = (m == 2'b01) ? "R4" : "R5";
    end else if (m != 2'b00 && ua >= 'h20000 && ua < 'h22000) begin
      v[25] = 1'b1; off = 32'(ua - 'h20000); tag = (m == 2'b01) ? "R4" : "R5";
    end else if (ua >= 'h69800 && ua < 'h6A000) begin
      v[20] = 1'b1; off = 32'(ua - 'h69800); tag = "R6";
    end else if (ua >= 'h6A000 && ua < 'h6C000) begin
      v[19] = 1'b1; off = 32'(ua - 'h6A000); tag = "R6";
    end else if (ua >= 'h120000 && ua < 'h120000 + 13 * 'h10000 &&
                 ((ua - 'h120000) % 'h10000) < 256) begin
      v[6 + int'((ua - 'h120000) / 'h10000)] = 1'b1;
      off = 32'(ua % 256); tag = "R7";
    end else begin
      for (int i = 0; i < 6; i++) begin
        if (ua >= longint'(sys_base(i)) && ua < longint'(sys_base(i)) + 256) begin
          v[1 + sys_line(i)] = 1'b1; off = 32'(ua % 256); tag = "R8";
        end
      end
    end
    if (v == '0) v[0] = 1'b1;
    return {v, off};
  endfunction

  task automatic check_addr(input logic [31:0] a);
    logic [57:0] e;
    string tag;
    @(negedge clk);
    addr = a;
    #5;
    e = expect_map(mode_o, a, tag);
    checks++;
    if (observed() != e[57:32] || local_offset != e[31:0]) begin
      errors++;
      $display("FAIL %s mode=%0d addr=%h: sel=%b off=%h expected sel=%b off=%h",
               tag, mode_o, a, observed(), local_offset, e[57:32], e[31:0]);
    end
    checks++;
    if ($countones(observed()) != 1) begin
      errors++;
      $display("FAIL R11 addr=%h: sel+err=%b expected exactly one bit", a, observed());
    end
  endtask

  task automatic write_mode(input logic [1:0] m);
    @(negedge clk);
    mode_we = 1'b1; mode_wdata = m;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic check_mode(input logic [1:0] exp, input string tag);
    checks++;
    if (mode_o != exp) begin
      errors++;
      $display("FAIL %s mode_o=%b expected %b", tag, mode_o, exp);
    end
  endtask

  task automatic edge_points(input logic [31:0] base, input logic [31:0] span);
    check_addr(base - 1);
    check_addr(base);
    check_addr(base + span - 1);
    check_addr(base + span);
  endtask

  task automatic sweep();
    check_addr(32'h0);
    check_addr(32'h1FFF);
    check_addr(32'h2000);
    check_addr(32'h0003_FFFF);
    check_addr(32'hFFFF_FFFF);
    edge_points(32'h0002_0000, 32'h2000);
    for (int b = 0; b < 4; b++) begin
      edge_points(32'h8000 * b, 32'h8000);
      edge_points(32'h0004_0000 + 32'h8000 * b, 32'h8000);
    end
    edge_points(32'h0006_9800, 32'h800);
    edge_points(32'h0006_A000, 32'h2000);
    for (int k = 0; k < 13; k++) edge_points(32'h0012_0000 + 32'h0001_0000 * k, 32'h100);
    for (int i = 0; i < 6; i++) edge_points(sys_base(i), 32'h100);
    for (int i = 0; i < 6; i++) check_addr(sys_base(i) + 32'h80);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check_mode(2'b00, "R1");
    check_addr(32'h0);   // R1: address zero selects the ROM after reset
    sweep();

    write_mode(2'b01);
    check_mode(2'b01, "R10");
    sweep();

    // R10: reserved code leaves mode 01 in place, visible on mode_o and on decode of 0x0
    write_mode(2'b11);
    check_mode(2'b01, "R10");
    check_addr(32'h0);

    // R10: the new mode is used only after the write edge
    @(negedge clk);
    mode_we = 1'b1; mode_wdata = 2'b10; addr = 32'h0;
    #5;
    checks++;
    if (flash_sel != 4'b0001) begin
      errors++;
      $display("FAIL R10 before edge flash_sel=%b expected 0001", flash_sel);
    end
    @(negedge clk);
    mode_we = 1'b0;
    #5;
    checks++;
    if (flash_sel != 4'b0100) begin
      errors++;
      $display("FAIL R10 after edge flash_sel=%b expected 0100", flash_sel);
    end
    check_mode(2'b10, "R10");
    sweep();

    write_mode(2'b00);
    check_mode(2'b00, "R10");
    check_addr(32'h0003_E123);

    @(negedge clk);
    rst = 1'b1;
    write_mode(2'b01);
    rst = 1'b0;
    #1;
    check_mode(2'b00, "R1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule